// File: doc/BRIEF.md
# Two-Rank Byte-Loadable DAC Code Register

This block is the digital input stage of a 12-bit parallel-input converter. A host writes the code over a data bus split into a low byte and a high nibble. One active-low write strobe and two separate active-low byte selects steer each part into its own first-rank input register. A second-rank register holds the code that the converter core sees. It copies the first rank while an active-low load control is held low, and it keeps its value while the load control is high. An active-low clear empties both ranks at once.

The level-sensitive latch behaviour is modelled with registers that sample every control on each clock edge. While an enable is held low, the register follows its inputs with one cycle of delay. The value sampled on the last enabled cycle is held once the enable is released. Both byte selects can be driven together, so that a single write loads all twelve bits. A parameter can instead route the high nibble from data bits 0 to 3, so that an 8-bit host loads the word in two writes. The output code runs from 0x000 (zero scale) to 0xFFF (full scale less one LSB).

Top module: `dac_code_reg`

## Requirements
- R1: On a clock edge where `wr_n` and `sel_lo_n` are both sampled low, the low input register takes `data_in[7:0]`.
- R2: On a clock edge where `wr_n` and `sel_hi_n` are both sampled low, the high input register takes `data_in[11:8]` when `NARROW_BUS` is 0.
- R3: When `wr_n` is high, or when a byte's select is high, that input register keeps its value. The value sampled on the last enabled edge is the one that is kept.
- R4: With both selects and `wr_n` low, all twelve bits load in one write.
- R5: While `ld_n` is sampled low, `dac_code` after that edge equals the new contents of the input registers, including a write made on the same edge.
- R6: While `ld_n` is sampled high, `dac_code` does not change, whatever writes are made to the input registers.
- R7: On an edge where `clr_n` is sampled low, both input registers and `dac_code` become 0x000. This overrides every write and load condition.
- R8: A write to one byte leaves the other input byte unchanged. This is observed through a later load.
- R9: With `NARROW_BUS` = 1, the high input register takes `data_in[3:0]` instead of `data_in[11:8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| clr_n | input | 1 | Clear, active low, clears both ranks |
| wr_n | input | 1 | Write strobe, active low |
| sel_lo_n | input | 1 | Low byte select, active low |
| sel_hi_n | input | 1 | High nibble select, active low |
| ld_n | input | 1 | Load control for the second rank, active low |
| data_in | input | 12 | Data bus |
| dac_code | output | 12 | Second-rank code for the converter core |

## Verification
The bench builds two copies of the block from the same stimulus. The first uses the default `NARROW_BUS` = 0. The second sets `NARROW_BUS` = 1, so that the two-write, 8-bit host sequence can be compared against the split-bus routing of the same writes. With the default widths of 8 and 4 bits, the codes 0x000 and 0xFFF can both be reached. The table walk interleaves byte writes with the load held high and released, which tests both the isolation of the second rank and the forwarding of a same-edge write.

// File: rtl/dac_code_pkg.sv
package dac_code_pkg;
  localparam int unsigned LO_BITS = 8;
  localparam int unsigned HI_BITS = 4;
  localparam int unsigned CODE_BITS = LO_BITS + HI_BITS;
endpackage

// File: rtl/dac_in_rank.sv
module dac_in_rank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);
  // clear wins, then write enable, else hold
  always_comb begin
    if (!clr_n)  q_next = '0;
    else if (en) q_next = d;
    else         q_next = q;
  end

  always_ff @(posedge clk) begin
    q <= q_next;
  end
endmodule

// File: rtl/dac_out_rank.sv
module dac_out_rank #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load,
  input  logic [W-1:0] src,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!clr_n)    q <= '0;
    else if (load) q <= src;
  end
endmodule

// File: rtl/dac_code_reg.sv
module dac_code_reg
  import dac_code_pkg::*;
#(
  parameter int unsigned LO_W       = LO_BITS,
  parameter int unsigned HI_W       = HI_BITS,
  parameter bit          NARROW_BUS = 1'b0
) (
  input  logic                 clk,
  input  logic                 clr_n,
  input  logic                 wr_n,
  input  logic                 sel_lo_n,
  input  logic                 sel_hi_n,
  input  logic                 ld_n,
  input  logic [LO_W+HI_W-1:0] data_in,
  output logic [LO_W+HI_W-1:0] dac_code
);
  localparam int unsigned CW = LO_W + HI_W;

  logic            lo_en, hi_en;
  logic [HI_W-1:0] hi_src;
  logic [LO_W-1:0] lo_q, lo_next;
  logic [HI_W-1:0] hi_q, hi_next;

  assign lo_en = !wr_n && !sel_lo_n;
  assign hi_en = !wr_n && !sel_hi_n;

  // routing of the high nibble: own lines or shared low lines
  generate
    if (NARROW_BUS) begin : g_narrow
      assign hi_src = data_in[HI_W-1:0];
    end else begin : g_split
      assign hi_src = data_in[CW-1:LO_W];
    end
  endgenerate

  dac_in_rank #(.W(LO_W)) u_lo (
    .clk(clk), .clr_n(clr_n), .en(lo_en),
    .d(data_in[LO_W-1:0]), .q(lo_q), .q_next(lo_next)
  );

  dac_in_rank #(.W(HI_W)) u_hi (
    .clk(clk), .clr_n(clr_n), .en(hi_en),
    .d(hi_src), .q(hi_q), .q_next(hi_next)
  );

  // second rank sees the first rank's next value so a held-low load
  // passes a same-edge write straight through
  dac_out_rank #(.W(CW)) u_out (
    .clk(clk), .clr_n(clr_n), .load(!ld_n),
    .src({hi_next, lo_next}), .q(dac_code)
  );
endmodule

// File: rtl/dac_code_reg_chk.sv
module dac_code_reg_chk #(
  parameter int unsigned LO_W = 8,
  parameter int unsigned HI_W = 4
) (
  input logic                 clk,
  input logic                 clr_n,
  input logic                 wr_n,
  input logic                 sel_lo_n,
  input logic                 sel_hi_n,
  input logic                 ld_n,
  input logic [LO_W+HI_W-1:0] data_in,
  input logic [LO_W+HI_W-1:0] dac_code,
  input logic [LO_W-1:0]      lo_q,
  input logic [HI_W-1:0]      hi_q
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | !clr_n;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> (dac_code == '0 && lo_q == '0 && hi_q == '0)); // R7

  AST_NOLOAD_HOLD: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && ld_n) |=> $stable(dac_code)); // R6

  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && (wr_n || sel_lo_n)) |=> $stable(lo_q)); // R3

  AST_LO_CAPTURE: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !wr_n && !sel_lo_n) |=> lo_q == $past(data_in[LO_W-1:0])); // R1

  AST_LOAD_FOLLOW: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !ld_n) |=> dac_code == {hi_q, lo_q}); // R5
endmodule

bind dac_code_reg dac_code_reg_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .clr_n(clr_n), .wr_n(wr_n), .sel_lo_n(sel_lo_n),
  .sel_hi_n(sel_hi_n), .ld_n(ld_n), .data_in(data_in),
  .dac_code(dac_code), .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/sim_dac_code_reg.sv
module sim_dac_code_reg;
  localparam int CLK_P = 10;
  localparam int NV = 14;
  // {clr_n, wr_n, sel_lo_n, sel_hi_n, ld_n, data[11:0], expected[11:0]}
  localparam logic [28:0] VEC [NV] = '{
    {5'b01111, 12'h000, 12'h000},  // R7 clear
    {5'b10011, 12'hA5C, 12'h000},  // R1/R6 low write, load high
    {5'b10101, 12'h3FF, 12'h000},  // R2/R6 high write, load high
    {5'b11110, 12'h777, 12'h35C},  // R5 load
    {5'b10000, 12'hABC, 12'hABC},  // R4 one-write full load
    {5'b11000, 12'h123, 12'hABC},  // R3 strobe high
    {5'b10110, 12'h456, 12'hABC},  // R3 no select
    {5'b10011, 12'hF11, 12'hABC},  // R6 write, load high
    {5'b11110, 12'h000, 12'hA11},  // R8 high byte untouched
    {5'b10101, 12'h0FF, 12'hA11},  // R6
    {5'b11110, 12'h000, 12'h011},  // R8 low byte untouched
    {5'b10000, 12'hFFF, 12'hFFF},  // R4 full scale code
    {5'b00000, 12'h555, 12'h000},  // R7 priority over write+load
    {5'b11110, 12'h000, 12'h000}   // R7 inputs cleared too
  };

  logic clk = 1'b0;
  logic clr_n = 1'b0, wr_n = 1'b1, sel_lo_n = 1'b1, sel_hi_n = 1'b1, ld_n = 1'b1;
  logic [11:0] data_in = '0;
  logic [11:0] code0, code1;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  dac_code_reg u0 (.clk(clk), .clr_n(clr_n), .wr_n(wr_n), .sel_lo_n(sel_lo_n),
    .sel_hi_n(sel_hi_n), .ld_n(ld_n), .data_in(data_in), .dac_code(code0));
  dac_code_reg #(.NARROW_BUS(1'b1)) u1 (.clk(clk), .clr_n(clr_n), .wr_n(wr_n),
    .sel_lo_n(sel_lo_n), .sel_hi_n(sel_hi_n), .ld_n(ld_n), .data_in(data_in),
    .dac_code(code1));

  function automatic string row_tag(input int r);
    case (r)
      0, 12, 13: return "R7";
      1:         return "R1";
      2:         return "R2";
      3:         return "R5";
      4, 11:     return "R4";
      5, 6:      return "R3";
      7, 9:      return "R6";
      default:   return "R8";
    endcase
  endfunction

  task automatic chk(input logic [11:0] act, input logic [11:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] c, input logic [11:0] d);
    {clr_n, wr_n, sel_lo_n, sel_hi_n, ld_n} = c;
    data_in = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    // R7 reset state: clear held while writes and load are active
    apply(5'b00000, 12'hFFF);
    apply(5'b00000, 12'hEEE);
    chk(code0, 12'h000, "R7 reset u0");
    chk(code1, 12'h000, "R7 reset u1");

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][28:24], VEC[i][23:12]);
      chk(code0, VEC[i][11:0], row_tag(i));
    end

    // R5/R1 transparency: output follows data while everything is held low
    apply(5'b10000, 12'h1E2);
    chk(code0, 12'h1E2, "R5 follow 1");
    apply(5'b10000, 12'h9D4);
    chk(code0, 12'h9D4, "R5 follow 2");
    apply(5'b11110, 12'h000);
    chk(code0, 12'h9D4, "R3 last value kept");

    // R9 narrow bus: two writes on low lines, load held high
    apply(5'b01111, 12'h000);
    apply(5'b10011, 12'h034);
    apply(5'b10101, 12'hAB9);
    chk(code1, 12'h000, "R6 narrow no load");
    apply(5'b11110, 12'h000);
    chk(code1, 12'h934, "R9 narrow bus");
    chk(code0, 12'hA34, "R2 split bus");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule